// File: doc/BRIEF.md
# Per-Stream Translation Control Bank

This block keeps the translation setup for every DMA stream that passes through an address-translation unit. For each stream it holds a small control word and four table-base registers. From them it drives, per stream, a decoded mode (blocked, translate or bypass), a flag that skips the prefetch stage, and the table-base addresses with their valid flags. These outputs go to a page-table walker, which sits outside this block.

Software reaches the bank through a 32-bit register port. Writes are single-cycle. Reads return data one cycle after the request, together with a valid strobe. A set of read-only parameter registers reports the page-size shift, bypass capability, the physical and virtual address widths and the number of streams.

A protect register holds a sticky lock bit. Once the lock is set, the bank ignores writes to every control and table-base register until reset, and reads still return the stored values. Each stream also raises a status flag when translation is selected but its first table base is not valid.

Top module: `strm_xlate_bank`

## Requirements
- R1: After reset every stream's control word is 0, so its mode is blocked (code 0). All table bases are invalid, the lock is clear, and reads of control and table-base registers return 0.
- R2: The control word of stream s is at byte address CTRL_BASE + 4·s (default CTRL_BASE = 0x1000). Only bits 2:0 are stored, and a read returns them with all upper bits 0.
- R3: The mode of stream s is on mode_o[2s+1:2s]. Code 2 (bypass) is selected when control bit 1 is set, whatever bit 0 holds. Otherwise code 1 (translate) is selected when bit 0 is set. Otherwise code 0 (blocked) is selected.
- R4: pf_bypass_o[s] equals control bit 2 of stream s, independent of the mode.
- R5: Table base i of stream s is at byte address TB_BASE + 4·(4·s + i) (default TB_BASE = 0x1400). Bit 0 is the valid flag and bits PA_W-PG_SH+1:2 hold the physical address shifted right by PG_SH (default 14). tb_valid_o[4s+i] gives the valid flag and tb_addr_o[(4s+i)·PA_W +: PA_W] gives the field shifted left by PG_SH.
- R6: In a table-base write, bit 1 and all bits above the address field are dropped, and they read back as 0.
- R7: no_tb_o[s] is 1 exactly when the mode of stream s is translate and its table base 0 is invalid.
- R8: The protect register is at 0x010. Writing bit 0 as 1 sets the lock. Writing 0 never clears it, only reset does. A read returns the lock in bit 0, and lock_o shows it.
- R9: While the lock is set, writes to control and table-base registers are dropped without error. Outputs and read-back keep their previous values.
- R10: The parameter registers report the following. At 0x000, the page-size shift in bits 27:24. At 0x004, bypass capability in bit 0. At 0x008, the physical address width in bits 29:24 and the virtual width in bits 21:16. At 0x00C, the stream count in bits 8:0.
- R11: reg_rvld rises in the cycle after a cycle with reg_rd high, and reg_rdata is valid at the same time. Unmapped addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW (14) | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvld |
| reg_rvld | output | 1 | Read data valid |
| lock_o | output | 1 | Lock state |
| mode_o | output | 2·NS (32) | Per-stream mode code |
| pf_bypass_o | output | NS (16) | Per-stream prefetch bypass |
| tb_valid_o | output | 4·NS (64) | Per-stream, per-index table-base valid |
| tb_addr_o | output | 4·NS·PA_W (2304) | Per-stream, per-index table-base physical address |
| no_tb_o | output | NS (16) | Translate selected with table base 0 invalid |

## Verification
The bench writes control value 3, which sets both mode bits. A design that gave translate priority would report translate here instead of bypass. It writes table-base words with bit 1 and high garbage bits set, which a design that stored the raw word would read back. It tries to clear the lock by writing 0, and then writes a control register and a table base while the lock is set, which catches a lock that can be cleared or that does not gate every register kind. It also checks the no-table-base flag in all three modes, and reads and writes unmapped addresses, to catch decode overlaps.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    MODE_BLOCK  = 2'd0,
    MODE_XLATE  = 2'd1,
    MODE_BYPASS = 2'd2
  } xlate_mode_e;

  // control word bit positions
  localparam int CB_XLATE = 0;
  localparam int CB_BYP   = 1;
  localparam int CB_PFBYP = 2;
  localparam int CTRL_W   = 3;

  // parameter/protect register word indices (byte address >> 2)
  localparam logic [2:0] PRM_PAGE  = 3'd0;
  localparam logic [2:0] PRM_CAPS  = 3'd1;
  localparam logic [2:0] PRM_WIDTH = 3'd2;
  localparam logic [2:0] PRM_COUNT = 3'd3;
  localparam logic [2:0] PRM_PROT  = 3'd4;

  function automatic xlate_mode_e mode_of(input logic [CTRL_W-1:0] c);
    if (c[CB_BYP])        return MODE_BYPASS;
    else if (c[CB_XLATE]) return MODE_XLATE;
    else                  return MODE_BLOCK;
  endfunction

endpackage

// File: rtl/stc_addr_dec.sv
module stc_addr_dec #(
  parameter int AW        = 14,
  parameter int NS        = 16,
  parameter int TB_PER    = 4,
  parameter int CTRL_BASE = 32'h1000,
  parameter int TB_BASE   = 32'h1400,
  localparam int SIDW     = (NS > 1) ? $clog2(NS) : 1,
  localparam int TBIW     = (TB_PER > 1) ? $clog2(TB_PER) : 1
) (
  input  logic [AW-1:0]   addr,
  output logic            ctrl_hit,
  output logic            tb_hit,
  output logic            prm_hit,
  output logic [2:0]      prm_idx,
  output logic [SIDW-1:0] ctrl_sid,
  output logic [SIDW-1:0] tb_sid,
  output logic [TBIW-1:0] tb_idx
);

  logic [31:0] a32;
  logic [31:0] c_off;
  logic [31:0] t_off;
  logic        aligned;

  always_comb begin
    a32      = 32'(addr);
    aligned  = (a32[1:0] == 2'b00);
    c_off    = a32 - 32'(CTRL_BASE);
    t_off    = a32 - 32'(TB_BASE);
    ctrl_hit = aligned && (a32 >= 32'(CTRL_BASE)) && (c_off < 32'(NS * 4));
    tb_hit   = aligned && (a32 >= 32'(TB_BASE)) && (t_off < 32'(NS * TB_PER * 4));
    prm_hit  = aligned && (a32 < 32'h14);
    prm_idx  = 3'(a32 >> 2);
    ctrl_sid = SIDW'(c_off >> 2);
    tb_idx   = TBIW'(t_off >> 2);
    tb_sid   = SIDW'(t_off >> (TBIW + 2));
  end

endmodule

// File: rtl/stc_stream.sv
module stc_stream
  import stc_pkg::*;
#(
  parameter int PA_W   = 36,
  parameter int PG_SH  = 14,
  parameter int TB_PER = 4,
  localparam int FLD_W = PA_W - PG_SH,
  localparam int TBIW  = (TB_PER > 1) ? $clog2(TB_PER) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              lock,
  input  logic                              ctrl_we,
  input  logic                              tb_we,
  input  logic [TBIW-1:0]                   tb_idx,
  input  logic [FLD_W+1:0]                  wdata,
  output logic [CTRL_W-1:0]                 ctrl_q,
  output logic [TB_PER-1:0]                 tb_vld_q,
  output logic [TB_PER-1:0][FLD_W-1:0]      tb_fld_q,
  output logic [1:0]                        mode_o,
  output logic                              pf_byp_o,
  output logic                              no_tb_o
);

  logic                ctrl_en;
  logic [CTRL_W-1:0]   ctrl_d;
  logic [TB_PER-1:0]   tb_en;
  xlate_mode_e         mode;

  // next state: control word
  always_comb begin
    ctrl_en = ctrl_we & ~lock;
    ctrl_d  = wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // table-base registers, one per index
  for (genvar i = 0; i < TB_PER; i++) begin : g_tb
    logic             vld_d;
    logic [FLD_W-1:0] fld_d;

    always_comb begin
      tb_en[i] = tb_we & ~lock & (tb_idx == TBIW'(i));
      vld_d    = wdata[0];
      fld_d    = wdata[FLD_W+1:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tb_vld_q[i] <= 1'b0;
        tb_fld_q[i] <= '0;
      end else if (tb_en[i]) begin
        tb_vld_q[i] <= vld_d;
        tb_fld_q[i] <= fld_d;
      end
    end
  end

  // decoded outputs
  always_comb begin
    mode     = mode_of(ctrl_q);
    mode_o   = mode;
    pf_byp_o = ctrl_q[CB_PFBYP];
    no_tb_o  = (mode == MODE_XLATE) && !tb_vld_q[0];
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !lock) |=> (ctrl_q == $past(wdata[CTRL_W-1:0]))); // R2
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(ctrl_q)); // R9
  AST_TB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(tb_vld_q) && $stable(tb_fld_q))); // R9
  AST_TB_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tb_en)); // R5

endmodule

// File: rtl/strm_xlate_bank.sv
module strm_xlate_bank
  import stc_pkg::*;
#(
  parameter int AW        = 14,
  parameter int NS        = 16,
  parameter int PA_W      = 36,
  parameter int VA_W      = 32,
  parameter int PG_SH     = 14,
  parameter int BYP_OK    = 1,
  parameter int CTRL_BASE = 32'h1000,
  parameter int TB_BASE   = 32'h1400,
  localparam int TB_PER   = 4,
  localparam int FLD_W    = PA_W - PG_SH,
  localparam int SIDW     = (NS > 1) ? $clog2(NS) : 1,
  localparam int TBIW     = $clog2(TB_PER)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [AW-1:0]               reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        reg_rvld,
  output logic                        lock_o,
  output logic [2*NS-1:0]             mode_o,
  output logic [NS-1:0]               pf_bypass_o,
  output logic [NS*TB_PER-1:0]        tb_valid_o,
  output logic [NS*TB_PER*PA_W-1:0]   tb_addr_o,
  output logic [NS-1:0]               no_tb_o
);

  localparam logic [31:0] PV_PAGE  = 32'(PG_SH % 16) << 24;
  localparam logic [31:0] PV_CAPS  = 32'(BYP_OK != 0);
  localparam logic [31:0] PV_WIDTH = (32'(PA_W % 64) << 24) | (32'(VA_W % 64) << 16);
  localparam logic [31:0] PV_COUNT = 32'(NS % 512);

  logic            ctrl_hit, tb_hit, prm_hit;
  logic [2:0]      prm_idx;
  logic [SIDW-1:0] ctrl_sid, tb_sid;
  logic [TBIW-1:0] tb_idx;

  logic            lock_q, lock_d, lock_en;
  logic [31:0]     rdata_q, rdata_d;
  logic            rvld_q;
  logic            unused_wd;

  logic [CTRL_W-1:0]               ctrl_all [NS];
  logic [TB_PER-1:0]               vld_all  [NS];
  logic [TB_PER-1:0][FLD_W-1:0]    fld_all  [NS];

  assign unused_wd = ^reg_wdata[31:FLD_W+2];

  stc_addr_dec #(
    .AW(AW), .NS(NS), .TB_PER(TB_PER),
    .CTRL_BASE(CTRL_BASE), .TB_BASE(TB_BASE)
  ) i_dec (
    .addr     (reg_addr),
    .ctrl_hit (ctrl_hit),
    .tb_hit   (tb_hit),
    .prm_hit  (prm_hit),
    .prm_idx  (prm_idx),
    .ctrl_sid (ctrl_sid),
    .tb_sid   (tb_sid),
    .tb_idx   (tb_idx)
  );

  for (genvar s = 0; s < NS; s++) begin : g_strm
    logic [1:0] m;
    logic       pf, nt;

    stc_stream #(.PA_W(PA_W), .PG_SH(PG_SH), .TB_PER(TB_PER)) i_strm (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (lock_q),
      .ctrl_we  (reg_wr & ctrl_hit & (ctrl_sid == SIDW'(s))),
      .tb_we    (reg_wr & tb_hit & (tb_sid == SIDW'(s))),
      .tb_idx   (tb_idx),
      .wdata    (reg_wdata[FLD_W+1:0]),
      .ctrl_q   (ctrl_all[s]),
      .tb_vld_q (vld_all[s]),
      .tb_fld_q (fld_all[s]),
      .mode_o   (m),
      .pf_byp_o (pf),
      .no_tb_o  (nt)
    );

    assign mode_o[2*s +: 2] = m;
    assign pf_bypass_o[s]   = pf;
    assign no_tb_o[s]       = nt;

    for (genvar i = 0; i < TB_PER; i++) begin : g_out
      assign tb_valid_o[s*TB_PER + i]             = vld_all[s][i];
      assign tb_addr_o[(s*TB_PER + i)*PA_W +: PA_W] = {fld_all[s][i], {PG_SH{1'b0}}};
    end
  end

  // lock: sticky set
  always_comb begin
    lock_en = reg_wr & prm_hit & (prm_idx == PRM_PROT) & reg_wdata[0];
    lock_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    if (prm_hit) begin
      case (prm_idx)
        PRM_PAGE:  rdata_d = PV_PAGE;
        PRM_CAPS:  rdata_d = PV_CAPS;
        PRM_WIDTH: rdata_d = PV_WIDTH;
        PRM_COUNT: rdata_d = PV_COUNT;
        PRM_PROT:  rdata_d = {31'd0, lock_q};
        default:   rdata_d = '0;
      endcase
    end else if (ctrl_hit) begin
      rdata_d = 32'(ctrl_all[ctrl_sid]);
    end else if (tb_hit) begin
      rdata_d = 32'({fld_all[tb_sid][tb_idx], 1'b0, vld_all[tb_sid][tb_idx]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvld_q <= 1'b0;
    else        rvld_q <= reg_rd;
  end

  assign reg_rdata = rdata_q;
  assign reg_rvld  = rvld_q;
  assign lock_o    = lock_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R8
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvld); // R11
  AST_NO_SPUR_RVLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvld); // R11
  AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_hit, tb_hit, prm_hit})); // R11

endmodule

// File: tb/test_strm_xlate_bank.sv
module test_strm_xlate_bank;

  localparam int NS    = 16;
  localparam int PA_W  = 36;
  localparam int AW    = 14;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     reg_wr, reg_rd;
  logic [AW-1:0]            reg_addr;
  logic [31:0]              reg_wdata;
  logic [31:0]              reg_rdata;
  logic                     reg_rvld;
  logic                     lock_o;
  logic [2*NS-1:0]          mode_o;
  logic [NS-1:0]            pf_bypass_o;
  logic [NS*4-1:0]          tb_valid_o;
  logic [NS*4*PA_W-1:0]     tb_addr_o;
  logic [NS-1:0]            no_tb_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  strm_xlate_bank i_strm_xlate_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvld(reg_rvld), .lock_o(lock_o), .mode_o(mode_o),
    .pf_bypass_o(pf_bypass_o), .tb_valid_o(tb_valid_o),
    .tb_addr_o(tb_addr_o), .no_tb_o(no_tb_o)
  );

  function automatic logic [AW-1:0] ctrl_at(input int s);
    return AW'(32'h1000 + 4 * s);
  endfunction

  function automatic logic [AW-1:0] tb_at(input int s, input int i);
    return AW'(32'h1400 + 4 * (4 * s + i));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    v = reg_rvld;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    chk("R1 mode", 64'(mode_o), 64'd0);
    chk("R1 tb_valid", 64'(tb_valid_o), 64'd0);
    chk("R1 lock", 64'(lock_o), 64'd0);
    rd(ctrl_at(3), d, v);
    chk("R1 ctrl read", 64'(d), 64'd0);
    rd(tb_at(9, 2), d, v);
    chk("R1 tb read", 64'(d), 64'd0);
  endtask

  task automatic t_params;
    logic [31:0] d; logic v;
    rd(14'h000, d, v); chk("R10 page shift", 64'(d), 64'h0E00_0000);
    chk("R11 rvld", 64'(v), 64'd1);
    @(negedge clk);
    chk("R11 rvld drops", 64'(reg_rvld), 64'd0);
    rd(14'h004, d, v); chk("R10 bypass cap", 64'(d), 64'h1);
    rd(14'h008, d, v); chk("R10 widths", 64'(d), 64'h2420_0000);
    rd(14'h00C, d, v); chk("R10 count", 64'(d), 64'd16);
  endtask

  task automatic t_mode;
    logic [31:0] d; logic v;
    wr(ctrl_at(5), 32'h1);
    chk("R3 translate", 64'(mode_o[11:10]), 64'd1);
    rd(ctrl_at(5), d, v); chk("R2 readback", 64'(d), 64'h1);
    wr(ctrl_at(5), 32'h3);
    chk("R3 bypass over translate", 64'(mode_o[11:10]), 64'd2);
    chk("R4 pf off", 64'(pf_bypass_o[5]), 64'd0);
    wr(ctrl_at(5), 32'h6);
    chk("R3 bypass", 64'(mode_o[11:10]), 64'd2);
    chk("R4 pf on", 64'(pf_bypass_o[5]), 64'd1);
    wr(ctrl_at(5), 32'h4);
    chk("R3 blocked", 64'(mode_o[11:10]), 64'd0);
    chk("R4 pf blocked", 64'(pf_bypass_o[5]), 64'd1);
    wr(ctrl_at(5), 32'hFFFF_FFF9);
    rd(ctrl_at(5), d, v); chk("R2 upper dropped", 64'(d), 64'h1);
    chk("R2 other stream", 64'(mode_o[9:8]), 64'd0);
  endtask

  task automatic t_tb;
    logic [31:0] d; logic v;
    logic [21:0] fld = 22'h2A_BCDE;
    wr(tb_at(2, 3), {8'h00, fld, 2'b01});
    chk("R5 valid", 64'(tb_valid_o[11]), 64'd1);
    chk("R5 addr", 64'(tb_addr_o[11*PA_W +: PA_W]), 64'({fld, 14'd0}));
    rd(tb_at(2, 3), d, v); chk("R5 readback", 64'(d), 64'({fld, 2'b01}));
    chk("R5 neighbour", 64'(tb_valid_o[10]), 64'd0);
    wr(tb_at(2, 3), {8'hA5, fld, 2'b10});
    rd(tb_at(2, 3), d, v); chk("R6 stray bits", 64'(d), 64'({fld, 2'b00}));
    chk("R6 valid off", 64'(tb_valid_o[11]), 64'd0);
  endtask

  task automatic t_notb;
    wr(ctrl_at(7), 32'h1);
    chk("R7 missing base", 64'(no_tb_o[7]), 64'd1);
    wr(tb_at(7, 0), 32'h0000_0101);
    chk("R7 base present", 64'(no_tb_o[7]), 64'd0);
    wr(tb_at(7, 0), 32'h0);
    wr(ctrl_at(7), 32'h3);
    chk("R7 bypass no flag", 64'(no_tb_o[7]), 64'd0);
    wr(ctrl_at(7), 32'h0);
    chk("R7 blocked no flag", 64'(no_tb_o[7]), 64'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic v;
    logic [2*NS-1:0] m0;
    m0 = mode_o;
    wr(14'h0FF0, 32'hFFFF_FFFF);
    wr(14'h1401, 32'hFFFF_FFFF);
    rd(14'h0FF0, d, v); chk("R11 unmapped read", 64'(d), 64'd0);
    rd(14'h0020, d, v); chk("R11 gap read", 64'(d), 64'd0);
    chk("R11 mode untouched", 64'(mode_o), 64'(m0));
    chk("R11 tb untouched", 64'(tb_valid_o[0]), 64'd0);
  endtask

  task automatic t_lock;
    logic [31:0] d; logic v;
    wr(ctrl_at(5), 32'h1);
    wr(tb_at(4, 1), 32'h0000_0005);
    wr(14'h010, 32'h0);
    chk("R8 zero no set", 64'(lock_o), 64'd0);
    wr(14'h010, 32'h1);
    chk("R8 set", 64'(lock_o), 64'd1);
    rd(14'h010, d, v); chk("R8 readback", 64'(d), 64'd1);
    wr(14'h010, 32'h0);
    chk("R8 sticky", 64'(lock_o), 64'd1);
    wr(ctrl_at(5), 32'h2);
    chk("R9 mode frozen", 64'(mode_o[11:10]), 64'd1);
    rd(ctrl_at(5), d, v); chk("R9 ctrl read", 64'(d), 64'h1);
    wr(tb_at(4, 1), 32'h0000_0000);
    chk("R9 tb frozen", 64'(tb_valid_o[17]), 64'd1);
    rd(tb_at(4, 1), d, v); chk("R9 tb read", 64'(d), 64'h5);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_params;
    t_mode;
    t_tb;
    t_notb;
    t_unmapped;
    t_lock;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule